// File: doc/BRIEF.md
# Paged Non-Volatile Byte Array Write Controller

This block sits on a small CPU data bus in front of an on-chip non-volatile byte array. The array is modelled as registers with a fixed programming delay. Data addresses 00h to 3Fh form a 64-byte window. A bank register maps that window onto one of up to two 64-byte banks. A control/status register switches the array off, enables programming, selects the write mode and reports a programming cycle in progress.

When the array is reachable, reads return array contents with the same one-cycle latency as any other register on the bus. Writes work in one of two modes. In single-byte mode, a write starts a programming cycle for that byte alone. In row mode, up to eight bytes of one aligned 8-byte row are collected in a latch, and a start command programs them together in one cycle. While a cycle runs, the control register stays frozen and the array cannot be accessed.

Top module: `eep_page_ctrl`

## Requirements
- R1: The bank register sits at address E8h and holds 2 bits. Value 1 selects bank 0. Value 2 selects bank 1, but only when two banks are built. Any other value selects no bank. With no bank selected, array reads return 00h and array writes have no effect.
- R2: Control bit2 (power-off) makes every array access invalid: reads return 00h and writes change nothing.
- R3: Control bit0 (enable) must be set for a write to be accepted. A write with bit0 clear leaves the array unchanged.
- R4: A programming cycle keeps busy (control bit1) set for exactly PROG_CYCLES cycles after the edge that starts it. The array bytes update on the edge that clears busy.
- R5: While busy, control reads return exactly 02h, array reads return 00h, and writes to the control register and to the array are ignored.
- R6: A valid read appears on rdata_o on the clock edge that samples re_i, so it can be observed in the following cycle.
- R7: With control bit3 clear, one accepted array write programs that single location.
- R8: With control bit3 set, accepted writes are collected in a row latch. Writing the control register with bit6, bit3 and bit0 set and bit2 clear then programs all collected bytes together. Bytes of the row that were not written keep their contents.
- R9: An accepted row-mode write to a different row or bank drops everything collected so far and restarts the latch with that byte.
- R10: A start command while the latch is empty starts no cycle.
- R11: The control register is at address EAh. Bits 4, 5, 6 and 7 read as zero, and writes to bits 4 and 5 are ignored.
- R12: After reset the control and bank registers read 00h and every array byte holds FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Bus address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |

## Verification
The bench builds the block with NUM_BANKS = 2 and PROG_CYCLES = 5. Two banks make the second bank reachable, so it is possible to show that the same window offset in each bank holds separate data. The short delay lets back-to-back status reads cover the whole busy window: five reads return 02h and the sixth returns 01h. Row mode is checked for partial masks, for row replacement, and for a start command with an empty latch.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int unsigned PAGE_BYTES = 64;
  localparam int unsigned ROW_BYTES  = 8;
  localparam int unsigned ROWS       = PAGE_BYTES / ROW_BYTES;
  localparam int unsigned OFS_W      = $clog2(PAGE_BYTES);
  localparam int unsigned ROW_W      = $clog2(ROWS);
  localparam int unsigned COL_W      = $clog2(ROW_BYTES);

  localparam int unsigned B_ENA   = 0;
  localparam int unsigned B_BUSY  = 1;
  localparam int unsigned B_OFF   = 2;
  localparam int unsigned B_PAR   = 3;
  localparam int unsigned B_START = 6;

  localparam logic [7:0] ERASED = 8'hFF;

  typedef struct packed {
    logic par;
    logic off;
    logic ena;
  } ctl_t;
endpackage

// File: rtl/eep_ctl_reg.sv
module eep_ctl_reg
  import eep_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       busy_i,
  output ctl_t       ctl_o,
  output logic       start_req_o
);
  ctl_t ctl_q;
  logic acc;

  assign acc = wr_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else if (acc) begin
      ctl_q.ena <= wdata_i[B_ENA];
      ctl_q.off <= wdata_i[B_OFF];
      ctl_q.par <= wdata_i[B_PAR];
    end
  end

  // start only with a consistent row-mode image
  assign start_req_o = acc && wdata_i[B_START] && wdata_i[B_PAR] &&
                       wdata_i[B_ENA] && !wdata_i[B_OFF];
  assign ctl_o = ctl_q;

  AST_BUSY_CTL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_i) |=> $stable(ctl_o)); // R5
endmodule

// File: rtl/eep_row_latch.sv
module eep_row_latch
  import eep_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic                    single_i,
  input  logic                    bank_i,
  input  logic [OFS_W-1:0]        ofs_i,
  input  logic [7:0]              data_i,
  input  logic                    clear_i,
  output logic                    bank_o,
  output logic [ROW_W-1:0]        row_o,
  output logic [ROW_BYTES*8-1:0]  data_o,
  output logic [ROW_BYTES-1:0]    mask_o
);
  logic                  bank_q;
  logic [ROW_W-1:0]      row_q;
  logic [7:0]            dat_q [ROW_BYTES];
  logic [ROW_BYTES-1:0]  mask_q;
  logic [ROW_W-1:0]      row_in;
  logic [COL_W-1:0]      col_in;
  logic                  fresh;

  assign row_in = ofs_i[OFS_W-1:COL_W];
  assign col_in = ofs_i[COL_W-1:0];
  assign fresh  = single_i || (mask_q == '0) || (row_in != row_q) || (bank_i != bank_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= 1'b0;
      row_q  <= '0;
      mask_q <= '0;
      for (int i = 0; i < ROW_BYTES; i++) dat_q[i] <= '0;
    end else if (clear_i) begin
      mask_q <= '0;
    end else if (load_i) begin
      bank_q        <= bank_i;
      row_q         <= row_in;
      dat_q[col_in] <= data_i;
      if (fresh) mask_q <= ROW_BYTES'(1) << col_in;
      else       mask_q <= mask_q | (ROW_BYTES'(1) << col_in);
    end
  end

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_out
    assign data_o[g*8 +: 8] = dat_q[g];
  end

  assign bank_o = bank_q;
  assign row_o  = row_q;
  assign mask_o = mask_q;

  AST_MASK_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (mask_o == '0)); // R8
  AST_SINGLE_ONE_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && single_i && !clear_i) |=> $onehot0(mask_o) && (mask_o != '0)); // R7
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int unsigned PROG_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q) begin
      if (done_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R4
  AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R4
endmodule

// File: rtl/eep_array.sv
module eep_array
  import eep_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    commit_i,
  input  logic                    wbank_i,
  input  logic [ROW_W-1:0]        wrow_i,
  input  logic [ROW_BYTES*8-1:0]  wdata_i,
  input  logic [ROW_BYTES-1:0]    wmask_i,
  input  logic                    rbank_i,
  input  logic [OFS_W-1:0]        rofs_i,
  output logic [7:0]              rdata_o
);
  localparam int unsigned DEPTH = NUM_BANKS * PAGE_BYTES;
  localparam int unsigned AW    = $clog2(DEPTH + 1);

  logic [7:0] mem_q [DEPTH];

  function automatic logic [AW-1:0] idx(input logic b, input logic [OFS_W-1:0] o);
    idx = (NUM_BANKS > 1 && b) ? AW'(PAGE_BYTES) + AW'(o) : AW'(o);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
    end else if (commit_i) begin
      for (int c = 0; c < ROW_BYTES; c++) begin
        if (wmask_i[c]) mem_q[idx(wbank_i, {wrow_i, COL_W'(c)})] <= wdata_i[c*8 +: 8];
      end
    end
  end

  assign rdata_o = mem_q[idx(rbank_i, rofs_i)];
endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl
  import eep_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 2,
  parameter int unsigned PROG_CYCLES = 16,
  parameter logic [7:0]  BANK_ADDR   = 8'hE8,
  parameter logic [7:0]  CTL_ADDR    = 8'hEA
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       we_i,
  input  logic       re_i,
  output logic [7:0] rdata_o
);
  logic                   win_hit, ctl_hit, bank_hit;
  logic [1:0]             bank_q;
  logic                   bank_ok, bank_idx, acc_ok, wr_arr;
  logic                   busy, done, start_req, start;
  ctl_t                   ctl;
  logic                   l_bank;
  logic [ROW_W-1:0]       l_row;
  logic [ROW_BYTES*8-1:0] l_data;
  logic [ROW_BYTES-1:0]   l_mask;
  logic [7:0]             arr_rd, rd_d, rdata_q;

  assign win_hit  = (addr_i < 8'(PAGE_BYTES));
  assign ctl_hit  = (addr_i == CTL_ADDR);
  assign bank_hit = (addr_i == BANK_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_q <= '0;
    else if (we_i && bank_hit) bank_q <= wdata_i[1:0];
  end

  assign bank_idx = (bank_q == 2'd2);
  assign bank_ok  = (bank_q == 2'd1) || (bank_idx && NUM_BANKS > 1);
  assign acc_ok   = bank_ok && !ctl.off && !busy;
  assign wr_arr   = we_i && win_hit && acc_ok && ctl.ena;
  assign start    = (wr_arr && !ctl.par) || (start_req && (l_mask != '0));

  eep_ctl_reg u_ctl (
    .clk_i, .rst_ni,
    .wr_i(we_i && ctl_hit), .wdata_i, .busy_i(busy),
    .ctl_o(ctl), .start_req_o(start_req)
  );

  eep_row_latch u_latch (
    .clk_i, .rst_ni,
    .load_i(wr_arr), .single_i(!ctl.par), .bank_i(bank_idx),
    .ofs_i(addr_i[OFS_W-1:0]), .data_i(wdata_i), .clear_i(done),
    .bank_o(l_bank), .row_o(l_row), .data_o(l_data), .mask_o(l_mask)
  );

  eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .busy_o(busy), .done_o(done)
  );

  eep_array #(.NUM_BANKS(NUM_BANKS)) u_array (
    .clk_i, .rst_ni,
    .commit_i(done), .wbank_i(l_bank), .wrow_i(l_row), .wdata_i(l_data), .wmask_i(l_mask),
    .rbank_i(bank_idx), .rofs_i(addr_i[OFS_W-1:0]), .rdata_o(arr_rd)
  );

  always_comb begin
    rd_d = 8'h00;
    if (ctl_hit) begin
      rd_d[B_BUSY] = busy;
      if (!busy) begin
        rd_d[B_ENA] = ctl.ena;
        rd_d[B_OFF] = ctl.off;
        rd_d[B_PAR] = ctl.par;
      end
    end else if (bank_hit) begin
      rd_d[1:0] = bank_q;
    end else if (win_hit && acc_ok) begin
      rd_d = arr_rd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (re_i) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;

  AST_CTL_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && ctl_hit) |=> (rdata_o[7:4] == 4'h0)); // R11
  AST_BUSY_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && ctl_hit && busy) |=> (rdata_o == 8'h02)); // R5
  AST_INVALID_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && win_hit && (busy || ctl.off || !bank_ok)) |=> (rdata_o == 8'h00)); // R2
  AST_EMPTY_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req && (l_mask == '0) && !busy) |=> !busy); // R10
endmodule

// File: tb/eep_page_ctrl_tb.sv
module eep_page_ctrl_tb_top;
  localparam int P = 5;
  localparam logic [7:0] BANK = 8'hE8;
  localparam logic [7:0] CTL  = 8'hEA;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic we_i = 1'b0, re_i = 1'b0;
  logic [7:0] rdata_o;

  always #5 clk_i = ~clk_i;

  eep_page_ctrl #(.NUM_BANKS(2), .PROG_CYCLES(P)) dut_i (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .re_i, .rdata_o
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int n_run = 0, n_fail = 0;
  logic issued_q = 1'b0;

  always @(posedge clk_i) issued_q <= re_i;

  // monitor: compare each completed read against the queue head
  always @(negedge clk_i) begin
    if (issued_q) begin
      n_run++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL %s: read with no expected item, actual %02h expected none", "R6", rdata_o);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (rdata_o !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, rdata_o, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1; re_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk_i);
    addr_i = a; we_i = 1'b0; re_i = 1'b1;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      we_i = 1'b0; re_i = 1'b0;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    // R12 reset state
    rd(CTL, 8'h00, "R12 ctl");
    rd(BANK, 8'h00, "R12 bank");
    // R1 no bank: access invalid
    wr(CTL, 8'h01);
    wr(8'h10, 8'h55);
    rd(8'h10, 8'h00, "R1 no-bank read");
    idle(P + 2);
    wr(BANK, 8'h01);
    rd(8'h10, 8'hFF, "R1 no-bank write ignored / R12 erased");
    // R7 byte mode, R4 busy window
    wr(8'h05, 8'hA5);
    for (int k = 0; k < P; k++) rd(CTL, 8'h02, "R4 busy window / R5 busy-only read");
    rd(CTL, 8'h01, "R4 busy cleared");
    rd(8'h05, 8'hA5, "R7 byte programmed / R6 read");
    // R5 array read, array write, ctl write during busy
    wr(8'h06, 8'h3C);
    rd(8'h06, 8'h00, "R5 read during busy");
    wr(8'h08, 8'h99);
    wr(CTL, 8'h00);
    idle(P + 2);
    rd(CTL, 8'h01, "R5 ctl write ignored");
    rd(8'h06, 8'h3C, "R7 second byte");
    rd(8'h08, 8'hFF, "R5 array write ignored");
    // R3 enable clear
    wr(CTL, 8'h00);
    wr(8'h07, 8'h12);
    idle(P + 2);
    wr(CTL, 8'h01);
    rd(8'h07, 8'hFF, "R3 write without enable");
    // R2 power off
    wr(CTL, 8'h05);
    wr(8'h07, 8'h33);
    rd(8'h07, 8'h00, "R2 read while off");
    idle(P + 2);
    wr(CTL, 8'h01);
    rd(8'h07, 8'hFF, "R2 write while off ignored");
    // R8 row mode
    wr(CTL, 8'h09);
    wr(8'h10, 8'h10); wr(8'h11, 8'h11); wr(8'h13, 8'h13);
    rd(CTL, 8'h09, "R8 no busy before start");
    rd(8'h11, 8'hFF, "R8 not programmed before start");
    wr(CTL, 8'h49);
    rd(CTL, 8'h02, "R8 start sets busy");
    idle(P + 2);
    rd(8'h10, 8'h10, "R8 row byte0");
    rd(8'h11, 8'h11, "R8 row byte1");
    rd(8'h12, 8'hFF, "R8 unwritten byte kept");
    rd(8'h13, 8'h13, "R8 row byte3");
    rd(CTL, 8'h09, "R11 start bit reads zero");
    // R9 row replace
    wr(8'h18, 8'hAA);
    wr(8'h20, 8'hBB);
    wr(CTL, 8'h49);
    idle(P + 2);
    rd(8'h18, 8'hFF, "R9 dropped byte");
    rd(8'h20, 8'hBB, "R9 new row byte");
    // R10 empty start
    wr(CTL, 8'h49);
    rd(CTL, 8'h09, "R10 empty start no busy");
    // R11 reserved bits
    wr(CTL, 8'h39);
    rd(CTL, 8'h09, "R11 reserved bits");
    // R1 second bank
    wr(CTL, 8'h01);
    wr(BANK, 8'h02);
    rd(BANK, 8'h02, "R1 bank readback");
    rd(8'h05, 8'hFF, "R1 bank1 separate");
    wr(8'h05, 8'h77);
    idle(P + 2);
    rd(8'h05, 8'h77, "R1 bank1 write");
    wr(BANK, 8'h01);
    rd(8'h05, 8'hA5, "R1 bank0 kept");
    wr(BANK, 8'h03);
    rd(8'h05, 8'h00, "R1 invalid bank code");
    idle(4);
    if (sb_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R6: actual %0d pending reads expected 0", sb_q.size());
    end
    summary();
    $finish;
  end
endmodule